// File: doc/BRIEF.md
# Next-Address Unit with Jump Delay Slot

This unit sits beside the decoder of a core that runs a compressed 16-bit instruction encoding. For each instruction step it receives the step's own address, the address of the instruction that follows it, a decoded control-flow class, the raw immediate bits, one register operand and the compare-result register. From these it produces the address to fetch next and a return-address write for linking jumps. Bit 0 of every produced address carries the instruction-encoding mode.

Conditional and unconditional branches redirect at once. Jumps are different: they always let exactly one following halfword instruction execute, the delay slot, before the jump target takes effect. The unit holds the pending target and the jump's own address in registers across that one step. While the delay-slot step runs it presents the jump's address as the base for PC-relative work, rounded down to 4 and to 8 bytes. Steps arrive on a valid/ready pair. Ready is high whenever reset is low, so upstream may present one step every cycle. A cycle with valid low is an idle cycle: it changes no state and the unit repeats the current address. Every output is a combinational function of the step and the registered slot state.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high, `next_pc` equals the parameter RESET_VEC and `step_ready` is low. On the first cycle after reset, `in_slot` is low, even if a jump was pending when reset rose.
- R2: The `kind` codes are: 0 sequential, 1 branch if register zero, 2 branch if register nonzero, 3 branch if compare register zero, 4 branch if compare register nonzero, 5 unconditional branch, 6 long link jump keeping the mode, 7 long link jump switching the mode, 8 register jump, 9 register link jump. Codes 10 to 15 act as code 0. A sequential step outside a delay slot gives `next_pc` = `fall_pc` with `link_we` low.
- R3: Kinds 1 and 2 test `reg_val`. A taken branch gives `fall_pc` + 2 × offset. The offset is `imm[7:0]` sign-extended when `ext_form` is 0, and `imm[15:0]` sign-extended when `ext_form` is 1. A branch that is not taken gives `fall_pc`.
- R4: Kinds 3 and 4 test `cond_val` instead of `reg_val`. Otherwise they use the same offset and target rule as R3.
- R5: Kind 5 is always taken. Its offset is `imm[10:0]` sign-extended in short form and `imm[15:0]` sign-extended in extended form, scaled by 2 and added to `fall_pc`.
- R6: Kinds 6 and 7 aim at {`fall_pc[31:28]`, `imm[25:0]`, 2'b00}. Kind 6 then sets bit 0 and kind 7 leaves it clear. `mode_bit` always equals bit 0 of `next_pc`.
- R7: Kinds 8 and 9 aim at `reg_val` unchanged, including its bit 0.
- R8: Kinds 6, 7 and 9, accepted outside a delay slot, raise `link_we` in that same cycle with `link_val` = `fall_pc` + 2. No other step raises `link_we`.
- R9: An accepted jump (kinds 6 to 9) outside a slot gives `next_pc` = `fall_pc` and sets `in_slot` on the next edge. The next accepted step gives the held target as `next_pc` and clears `in_slot`. Idle cycles in between keep the pending state and give `next_pc` = `cur_pc`.
- R10: A branch or jump whose step falls in a delay slot has no effect. `next_pc` is still the held target, `link_we` stays low, and no new slot opens.
- R11: `base_word` and `base_dword` are the base address with bits [1:0], respectively [2:0], cleared. The base address is `cur_pc` outside a slot and the address of the pending jump inside one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_valid | input | 1 | A step is presented this cycle |
| step_ready | output | 1 | Step accepted when valid; high whenever reset is low |
| cur_pc | input | 32 | Address of the presented step |
| fall_pc | input | 32 | Address of the instruction after the step |
| kind | input | 4 | Control-flow class (codes in R2) |
| ext_form | input | 1 | Step carries an extension prefix |
| imm | input | 26 | Raw immediate bits |
| reg_val | input | 32 | Selected register operand |
| cond_val | input | 32 | Compare-result register |
| next_pc | output | 32 | Address to fetch next, bit 0 is the mode |
| mode_bit | output | 1 | Mode of the next address |
| link_we | output | 1 | Write return address |
| link_val | output | 32 | Return address to write |
| in_slot | output | 1 | Current step sits in a jump delay slot |
| base_word | output | 32 | PC-relative base rounded to 4 bytes |
| base_dword | output | 32 | PC-relative base rounded to 8 bytes |

## Verification
Two functions can meet in one cycle: the release of a held jump target, and the arrival of a new control-flow step that would otherwise redirect or link. The bench provokes this by placing taken branches, long link jumps and register link jumps directly in delay slots, sometimes after idle cycles. A behavioural model then judges each such cycle: `next_pc` must still be the earlier target, `link_we` must stay low, and the base address must be the jump's address. Randomised mixes with random valid gaps and occasional resets repeat the collision many times.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [3:0] {
    FLOW_SEQ   = 4'd0,
    FLOW_BEQZ  = 4'd1,
    FLOW_BNEZ  = 4'd2,
    FLOW_BTEQZ = 4'd3,
    FLOW_BTNEZ = 4'd4,
    FLOW_BR    = 4'd5,
    FLOW_JAL   = 4'd6,
    FLOW_JALX  = 4'd7,
    FLOW_JR    = 4'd8,
    FLOW_JALR  = 4'd9
  } flow_e;

  function automatic logic flow_is_jump(input logic [3:0] k);
    return (k == FLOW_JAL) || (k == FLOW_JALX) || (k == FLOW_JR) || (k == FLOW_JALR);
  endfunction

  function automatic logic flow_is_link(input logic [3:0] k);
    return (k == FLOW_JAL) || (k == FLOW_JALX) || (k == FLOW_JALR);
  endfunction
endpackage

// File: rtl/npc_branch.sv
module npc_branch #(
  parameter int AW    = 32,
  parameter int IMM_W = 26,
  parameter int SHORT_W = 8,
  parameter int UNC_W   = 11,
  parameter int EXT_W   = 16
) (
  input  logic [3:0]       kind,
  input  logic             ext_form,
  input  logic [IMM_W-1:0] imm,
  input  logic [AW-1:0]    fall_pc,
  input  logic [AW-1:0]    reg_val,
  input  logic [AW-1:0]    cond_val,
  output logic             taken,
  output logic [AW-1:0]    target
);
  import npc_pkg::*;

  logic [AW-1:0] offset;
  logic          reg_zero;
  logic          cond_zero;

  assign reg_zero  = (reg_val == '0);
  assign cond_zero = (cond_val == '0);

  always_comb begin
    if (ext_form)
      offset = AW'($signed(imm[EXT_W-1:0]));
    else if (kind == FLOW_BR)
      offset = AW'($signed(imm[UNC_W-1:0]));
    else
      offset = AW'($signed(imm[SHORT_W-1:0]));
  end

  always_comb begin
    unique case (kind)
      FLOW_BEQZ:  taken = reg_zero;
      FLOW_BNEZ:  taken = !reg_zero;
      FLOW_BTEQZ: taken = cond_zero;
      FLOW_BTNEZ: taken = !cond_zero;
      FLOW_BR:    taken = 1'b1;
      default:    taken = 1'b0;
    endcase
  end

  assign target = fall_pc + (offset << 1);
endmodule

// File: rtl/npc_jump.sv
module npc_jump #(
  parameter int AW         = 32,
  parameter int IMM_W      = 26,
  parameter int REGION_LSB = 28
) (
  input  logic [3:0]       kind,
  input  logic [IMM_W-1:0] imm,
  input  logic [AW-1:0]    fall_pc,
  input  logic [AW-1:0]    reg_val,
  output logic [AW-1:0]    target,
  output logic [AW-1:0]    link_val
);
  import npc_pkg::*;

  localparam int JIMM_W = REGION_LSB - 2;

  logic [AW-1:0] region_tgt;

  assign region_tgt = {fall_pc[AW-1:REGION_LSB], imm[JIMM_W-1:0], 2'b00};

  always_comb begin
    unique case (kind)
      FLOW_JAL:  target = region_tgt | AW'(1);
      FLOW_JALX: target = region_tgt & ~AW'(1);
      default:   target = reg_val;
    endcase
  end

  assign link_val = fall_pc + AW'(2);
endmodule

// File: rtl/npc_slot.sv
module npc_slot #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic          arm,
  input  logic [AW-1:0] arm_target,
  input  logic [AW-1:0] arm_pc,
  output logic          in_slot,
  output logic [AW-1:0] held_target,
  output logic [AW-1:0] held_pc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      in_slot     <= 1'b0;
      held_target <= '0;
      held_pc     <= '0;
    end else if (accept) begin
      in_slot <= arm;
      if (arm) begin
        held_target <= arm_target;
        held_pc     <= arm_pc;
      end
    end
  end
endmodule

// File: rtl/npc_base.sv
module npc_base #(
  parameter int AW = 32,
  parameter int NUM_ALIGN = 2,
  parameter int MIN_ALIGN_BITS = 2
) (
  input  logic                     in_slot,
  input  logic [AW-1:0]            cur_pc,
  input  logic [AW-1:0]            jump_pc,
  output logic [NUM_ALIGN-1:0][AW-1:0] aligned
);
  logic [AW-1:0] raw;

  assign raw = in_slot ? jump_pc : cur_pc;

  for (genvar g = 0; g < NUM_ALIGN; g++) begin : g_align
    localparam int LOWB = MIN_ALIGN_BITS + g;
    assign aligned[g] = {raw[AW-1:LOWB], LOWB'(0)};
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit #(
  parameter int            AW         = 32,
  parameter int            IMM_W      = 26,
  parameter int            REGION_LSB = 28,
  parameter logic [AW-1:0] RESET_VEC  = 32'h0000_1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_valid,
  output logic             step_ready,
  input  logic [AW-1:0]    cur_pc,
  input  logic [AW-1:0]    fall_pc,
  input  logic [3:0]       kind,
  input  logic             ext_form,
  input  logic [IMM_W-1:0] imm,
  input  logic [AW-1:0]    reg_val,
  input  logic [AW-1:0]    cond_val,
  output logic [AW-1:0]    next_pc,
  output logic             mode_bit,
  output logic             link_we,
  output logic [AW-1:0]    link_val,
  output logic             in_slot,
  output logic [AW-1:0]    base_word,
  output logic [AW-1:0]    base_dword
);
  import npc_pkg::*;

  logic          accept;
  logic          jump_step;
  logic          br_taken;
  logic [AW-1:0] br_target;
  logic [AW-1:0] jmp_target;
  logic [AW-1:0] held_target;
  logic [AW-1:0] held_pc;
  logic [1:0][AW-1:0] bases;

  assign step_ready = !rst;
  assign accept     = step_valid && step_ready;
  assign jump_step  = flow_is_jump(kind);

  npc_branch #(.AW(AW), .IMM_W(IMM_W)) u_branch (
    .kind     (kind),
    .ext_form (ext_form),
    .imm      (imm),
    .fall_pc  (fall_pc),
    .reg_val  (reg_val),
    .cond_val (cond_val),
    .taken    (br_taken),
    .target   (br_target)
  );

  npc_jump #(.AW(AW), .IMM_W(IMM_W), .REGION_LSB(REGION_LSB)) u_jump (
    .kind     (kind),
    .imm      (imm),
    .fall_pc  (fall_pc),
    .reg_val  (reg_val),
    .target   (jmp_target),
    .link_val (link_val)
  );

  npc_slot #(.AW(AW)) u_slot (
    .clk         (clk),
    .rst         (rst),
    .accept      (accept),
    .arm         (jump_step && !in_slot),
    .arm_target  (jmp_target),
    .arm_pc      (cur_pc),
    .in_slot     (in_slot),
    .held_target (held_target),
    .held_pc     (held_pc)
  );

  npc_base #(.AW(AW), .NUM_ALIGN(2), .MIN_ALIGN_BITS(2)) u_base (
    .in_slot (in_slot),
    .cur_pc  (cur_pc),
    .jump_pc (held_pc),
    .aligned (bases)
  );

  assign base_word  = bases[0];
  assign base_dword = bases[1];

  always_comb begin
    if (rst)
      next_pc = RESET_VEC;
    else if (!step_valid)
      next_pc = cur_pc;
    else if (in_slot)
      next_pc = held_target;
    else if (jump_step)
      next_pc = fall_pc;
    else if (br_taken)
      next_pc = br_target;
    else
      next_pc = fall_pc;
  end

  assign mode_bit = next_pc[0];
  assign link_we  = accept && !in_slot && flow_is_link(kind);
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
  parameter int            AW        = 32,
  parameter logic [AW-1:0] RESET_VEC = 32'h0000_1000
) (
  input logic          clk,
  input logic          rst,
  input logic          step_valid,
  input logic [AW-1:0] fall_pc,
  input logic [3:0]    kind,
  input logic [AW-1:0] next_pc,
  input logic          mode_bit,
  input logic          link_we,
  input logic [AW-1:0] link_val,
  input logic          in_slot,
  input logic [AW-1:0] base_word,
  input logic [AW-1:0] base_dword
);
  logic jumpish;
  assign jumpish = (kind >= 4'd6) && (kind <= 4'd9);

  always_comb begin
    if (rst) a_r1_reset_vector: assert (next_pc == RESET_VEC);
  end

  a_r1_slot_cleared: assert property (@(posedge clk) rst |=> !in_slot);

  a_r9_jump_falls_through: assert property (@(posedge clk) disable iff (rst)
    (step_valid && !in_slot && jumpish) |-> next_pc == fall_pc);

  a_r9_slot_opens: assert property (@(posedge clk) disable iff (rst)
    (step_valid && !in_slot && jumpish) |=> in_slot);

  a_r9_slot_closes: assert property (@(posedge clk) disable iff (rst)
    (step_valid && in_slot) |=> !in_slot);

  a_r8_link_value: assert property (@(posedge clk) disable iff (rst)
    link_we |-> link_val == fall_pc + AW'(2));

  a_r10_no_link_in_slot: assert property (@(posedge clk) disable iff (rst)
    in_slot |-> !link_we);

  a_r11_bases_agree: assert property (@(posedge clk) disable iff (rst)
    base_word[AW-1:3] == base_dword[AW-1:3]);

  a_r6_mode_matches: assert property (@(posedge clk) disable iff (rst)
    mode_bit == next_pc[0]);
endmodule

bind npc_unit npc_unit_chk #(.AW(AW), .RESET_VEC(RESET_VEC)) u_chk (.*);

// File: tb/npc_unit_test.sv
module npc_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RVEC = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst;
  logic        step_valid;
  logic        step_ready;
  logic [31:0] cur_pc, fall_pc, reg_val, cond_val;
  logic [3:0]  kind;
  logic        ext_form;
  logic [25:0] imm;
  logic [31:0] next_pc, link_val, base_word, base_dword;
  logic        mode_bit, link_we, in_slot;

  npc_unit #(.RESET_VEC(RVEC)) uut (
    .clk(clk), .rst(rst), .step_valid(step_valid), .step_ready(step_ready),
    .cur_pc(cur_pc), .fall_pc(fall_pc), .kind(kind), .ext_form(ext_form),
    .imm(imm), .reg_val(reg_val), .cond_val(cond_val), .next_pc(next_pc),
    .mode_bit(mode_bit), .link_we(link_we), .link_val(link_val),
    .in_slot(in_slot), .base_word(base_word), .base_dword(base_dword)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  // reference model state
  bit          m_slot = 0;
  logic [31:0] m_tgt  = '0;
  logic [31:0] m_jpc  = '0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic string tag_of(input logic [3:0] k);
    case (k)
      4'd1, 4'd2: return "R3";
      4'd3, 4'd4: return "R4";
      4'd5:       return "R5";
      4'd6, 4'd7: return "R6";
      4'd8, 4'd9: return "R7";
      default:    return "R2";
    endcase
  endfunction

  // Drives one cycle, checks outputs mid-cycle, updates model at the edge.
  task automatic cyc(input bit r, input bit v, input logic [3:0] k, input bit e,
                     input logic [25:0] im, input logic [31:0] rv, input logic [31:0] cv,
                     input logic [31:0] cp);
    logic [31:0] fp, exp_pc, exp_tgt, base;
    int off;
    bit jmp, lnk, tk;
    rst = r; step_valid = v; kind = k; ext_form = e; imm = im;
    reg_val = rv; cond_val = cv; cur_pc = cp;
    fp = cp + (e ? 32'd4 : 32'd2);
    fall_pc = fp;
    #1;
    jmp = (k >= 4'd6) && (k <= 4'd9);
    lnk = (k == 4'd6) || (k == 4'd7) || (k == 4'd9);
    if (e) off = int'($signed(im[15:0]));
    else if (k == 4'd5) off = int'($signed(im[10:0]));
    else off = int'($signed(im[7:0]));
    case (k)
      4'd1: tk = (rv == 0);
      4'd2: tk = (rv != 0);
      4'd3: tk = (cv == 0);
      4'd4: tk = (cv != 0);
      4'd5: tk = 1;
      default: tk = 0;
    endcase
    if (k == 4'd6)      exp_tgt = {fp[31:28], im, 2'b00} + 32'd1;
    else if (k == 4'd7) exp_tgt = {fp[31:28], im, 2'b00};
    else                exp_tgt = rv;
    if (r) begin
      chk("R1 next_pc", next_pc, RVEC);
      chk("R1 ready", {31'd0, step_ready}, 32'd0);
    end else begin
      if (!v) begin
        exp_pc = cp;
        chk("R9 idle next_pc", next_pc, exp_pc);
      end else if (m_slot) begin
        exp_pc = m_tgt;
        chk((k == 0) ? "R9 release" : "R10 release over ctl", next_pc, exp_pc);
      end else if (jmp) begin
        exp_pc = fp;
        chk("R9 jump falls through", next_pc, exp_pc);
      end else begin
        exp_pc = tk ? (fp + 32'(off * 2)) : fp;
        chk(tag_of(k), next_pc, exp_pc);
      end
      chk("R6 mode", {31'd0, mode_bit}, {31'd0, exp_pc[0]});
      chk("R8 link_we", {31'd0, link_we}, {31'd0, (v && !m_slot && lnk)});
      if (v && !m_slot && lnk) chk("R8 link_val", link_val, fp + 32'd2);
      chk(m_slot ? "R10 in_slot" : "R9 in_slot", {31'd0, in_slot}, {31'd0, m_slot});
      base = m_slot ? m_jpc : cp;
      chk("R11 word", base_word, {base[31:2], 2'b00});
      chk("R11 dword", base_dword, {base[31:3], 3'b000});
    end
    @(posedge clk);
    if (r) m_slot = 0;
    else if (v) begin
      if (m_slot) m_slot = 0;
      else if (jmp) begin
        m_slot = 1; m_tgt = exp_tgt; m_jpc = cp;
      end
    end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset state
    cyc(1, 0, 0, 0, 0, 0, 0, 32'h100);
    cyc(1, 1, 4'd6, 0, 26'h10, 0, 0, 32'h100);
    chk("R1 in_slot after reset", {31'd0, in_slot}, 32'd0);
    // R2: sequential and unused codes
    cyc(0, 1, 4'd0, 0, 26'h3FF_FFFF, 5, 5, 32'h2000);
    cyc(0, 1, 4'd12, 1, 26'h1234, 0, 0, 32'h2002);
    // R3: zero / nonzero tests
    cyc(0, 1, 4'd1, 0, 26'h0F0, 0, 1, 32'h3000);     // taken, offset -16
    cyc(0, 1, 4'd1, 0, 26'h07F, 9, 0, 32'h3002);     // not taken
    cyc(0, 1, 4'd2, 1, 26'h0_8000, 7, 0, 32'h3004);  // ext, most negative
    cyc(0, 1, 4'd2, 0, 26'h044, 0, 0, 32'h3008);     // not taken
    // R4: compare-register branches ignore reg_val
    cyc(0, 1, 4'd3, 0, 26'h012, 0, 3, 32'h4000);     // reg zero, cond not: not taken
    cyc(0, 1, 4'd3, 0, 26'h012, 3, 0, 32'h4002);     // taken
    cyc(0, 1, 4'd4, 1, 26'h7FFF, 0, 1, 32'h4004);
    // R5: unconditional short and extended
    cyc(0, 1, 4'd5, 0, 26'h400, 0, 0, 32'h5000);     // -1024
    cyc(0, 1, 4'd5, 1, 26'h0_0C00, 0, 0, 32'h5004);
    // R6/R9: long jumps with idle cycles before the slot step
    cyc(0, 1, 4'd6, 0, 26'h2AB_CDEF, 0, 0, 32'h7000_0010);
    cyc(0, 0, 4'd0, 0, 0, 0, 0, 32'h7000_0012);
    cyc(0, 0, 4'd0, 0, 0, 0, 0, 32'h7000_0012);
    cyc(0, 1, 4'd0, 0, 0, 0, 0, 32'h7000_0012);
    cyc(0, 1, 4'd7, 1, 26'h155_5555, 0, 0, 32'hA000_0100);
    cyc(0, 1, 4'd0, 0, 0, 0, 0, 32'hA000_0104);
    // R7: register jumps, odd target kept
    cyc(0, 1, 4'd8, 0, 0, 32'h1234_5679, 0, 32'h600);
    cyc(0, 1, 4'd0, 0, 0, 0, 0, 32'h602);
    cyc(0, 1, 4'd9, 0, 0, 32'h0000_8000, 0, 32'h700);
    cyc(0, 1, 4'd0, 0, 0, 0, 0, 32'h702);
    // R10: control steps inside a delay slot
    cyc(0, 1, 4'd6, 0, 26'h000_0100, 0, 0, 32'h0000_0806);
    cyc(0, 1, 4'd1, 0, 26'h0F0, 0, 0, 32'h0000_0808);
    cyc(0, 1, 4'd0, 0, 0, 0, 0, 32'h0000_0401);
    cyc(0, 1, 4'd9, 0, 0, 32'h900, 0, 32'h0000_080E);
    cyc(0, 1, 4'd9, 0, 0, 32'hA00, 0, 32'h0000_0810);
    cyc(0, 1, 4'd0, 0, 0, 0, 0, 32'h900);
    // R1: reset while a jump is pending
    cyc(0, 1, 4'd8, 0, 0, 32'hBEE0, 0, 32'hC00);
    cyc(1, 0, 4'd0, 0, 0, 0, 0, 32'hC02);
    cyc(0, 1, 4'd0, 0, 0, 0, 0, 32'hC02);
    // randomised mix
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] cp;
      logic [3:0] k;
      cp = $urandom & 32'hFFFF_FFFE;
      k = 4'($urandom_range(0, 15));
      cyc(($urandom_range(0, 99) == 0), ($urandom_range(0, 3) != 0), k,
          1'($urandom), 26'($urandom),
          ($urandom_range(0, 2) == 0) ? 32'd0 : $urandom,
          ($urandom_range(0, 2) == 0) ? 32'd0 : $urandom, cp);
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule